// File: doc/BRIEF.md
# Privileged System Register Access Controller

This block owns two 128-bit translation-base registers: a hypervisor-level register and a guest-level register whose name can be steered onto the hypervisor copy. Each request carries the requester's privilege level (0 to 3), a read/write flag, a 64-bit or 128-bit width, a selector naming one of the two registers, and the control bits that govern the access. These are host mode, three nested-virtualization bits, read and write trap bits, fine-grained trap controls and enables for 128-bit access.

One cycle after a request, the block reports exactly one outcome:
- done: the register is read or written;
- redirect: the access goes to a memory slot, reported by its offset;
- undefined: an undefined-instruction result;
- trap: the access traps to level 2 or 3, with a 6-bit syndrome class.

The storage changes only on a done write. Read data is driven only for a done read.

Top module: `sysreg_access_ctrl`

## Requirements
- R1: Any request at privilege level 0, naming either register, gives the undefined outcome.
- R2: A level-1 request naming the hypervisor register traps to level 2 when nested-virtualization bit 0 is set, and is undefined otherwise. The trap class is 0x18 for a 64-bit access and 0x14 for a 128-bit access.
- R3: A 64-bit access works on bits [63:0] only. A 64-bit write leaves bits [127:64] unchanged. A 64-bit read returns zero on the upper half (`rdHi`).
- R4: A 128-bit write stores `wrHi` in bits [127:64] and `wrLo` in bits [63:0]. A 128-bit read returns the same halves on `rdHi` and `rdLo`.
- R5: Steering of the guest-register name:
  - at level 2, a request naming the guest register reaches the hypervisor register when `hostMode` is 1, and the guest register otherwise;
  - at level 3 the named register is always used;
  - the hypervisor name at levels 2 and 3 always reaches the hypervisor register.
- R6: A level-1 request naming the guest register is resolved by the first matching case in this order:
  - when level 2 is enabled, the read trap bit (for reads) or the write trap bit (for writes) traps to level 2;
  - an active fine-grained trap bit traps to level 2;
  - when all three nested-virtualization bits are 1, the access is redirected with offset 0x200;
  - otherwise the access is done on the guest register.
- R7: The fine-grained trap bits take effect only when level 2 is enabled, the fine-grained feature is present, and either level 3 is absent or `el3FgtEn` is 1.
- R8: When level 3 is present and `el3WideEn` is 0, a 128-bit access at level 1 or 2 that reaches the 128-bit checks resolves as follows:
  - undefined when `wideUndefPrio` is 1; at level 1 this takes effect before every other check;
  - otherwise undefined when `el3UndefSel` is 1;
  - otherwise a trap to level 3 with class 0x14.
- R9: For the guest name at level 1, a 128-bit access traps to level 2 (class 0x14) when level 2 is enabled and either `extCtlOn` or `el2WideEn` is 0. This check falls after the fine-grained check and before the level-3 trap.
- R10: Outcome reporting:
  - every request yields exactly one of done, redirect, undefined and trap, one cycle later, with `rspValid` high;
  - no request gives no response;
  - register contents change only on a done write.
- R11: Reset and read data:
  - both registers reset to zero on the synchronous active-high reset;
  - read data is zero for any response other than a done read;
  - `trapLevel` and `trapClass` are zero unless the outcome is trap;
  - `redirOffset` is zero unless the outcome is redirect.
- R12: With the default 8-bit identifier width, bits [63:56] of either register are always stored and read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Request present this cycle |
| reqLevel | input | 2 | Privilege level of the requester |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWide | input | 1 | 1 = 128-bit access, 0 = 64-bit access |
| reqSelHyp | input | 1 | 1 = names the hypervisor register, 0 = names the guest register |
| wrLo | input | 64 | First source word, written to bits [63:0] |
| wrHi | input | 64 | Second source word, written to bits [127:64] on a 128-bit write |
| hostMode | input | 1 | Host mode active |
| nvBits | input | 3 | Nested-virtualization control bits |
| el2Enabled | input | 1 | Level 2 enabled in the current security state |
| vmTrapRd | input | 1 | Trap guest-register reads from level 1 |
| vmTrapWr | input | 1 | Trap guest-register writes from level 1 |
| fgtPresent | input | 1 | Fine-grained trap feature present |
| el3Present | input | 1 | Level 3 implemented |
| el3FgtEn | input | 1 | Level-3 enable for fine-grained traps |
| fgtTrapRd | input | 1 | Fine-grained read trap for the guest register |
| fgtTrapWr | input | 1 | Fine-grained write trap for the guest register |
| el3WideEn | input | 1 | Level-3 enable for 128-bit access |
| wideUndefPrio | input | 1 | A cleared level-3 128-bit enable gives undefined with top priority |
| el3UndefSel | input | 1 | A cleared level-3 128-bit enable gives undefined instead of a trap |
| el2WideEn | input | 1 | Level-2 enable for 128-bit access |
| extCtlOn | input | 1 | Extended level-2 control register enabled |
| rspValid | output | 1 | Response present |
| rspDone | output | 1 | Outcome: access performed |
| rspRedirect | output | 1 | Outcome: redirected to memory |
| rspUndef | output | 1 | Outcome: undefined instruction |
| rspTrap | output | 1 | Outcome: trap |
| trapLevel | output | 2 | Trap target level |
| trapClass | output | 6 | Trap syndrome class |
| redirOffset | output | 12 | Memory slot offset on a redirect |
| rdLo | output | 64 | Read data, bits [63:0] |
| rdHi | output | 64 | Read data, bits [127:64] |

## Verification
The main decision is tried at each privilege level with each register name. Trap-bit, fine-grained and 128-bit enable patterns are set so that only one stage of the level-1 chain fires at a time, which separates a wrong priority from a wrong gate.

Writes of 64 and 128 bits are interleaved with full-width reads at level 3. This shows whether a narrow write disturbed the upper half, whether host mode steered the write to the right copy, and whether a trapped, undefined or redirected write left the storage untouched. Source data with its top byte set shows whether the identifier bits [63:56] are zeroed.

// File: rtl/sra_pkg.sv
package sra_pkg;
  typedef enum logic [1:0] {
    OUT_DONE  = 2'd0,
    OUT_REDIR = 2'd1,
    OUT_UNDEF = 2'd2,
    OUT_TRAP  = 2'd3
  } outcome_e;

  typedef struct packed {
    logic wrGuestLo;
    logic wrGuestHi;
    logic wrHypLo;
    logic wrHypHi;
    logic rdGuest;
    logic rdHyp;
    logic rdWide;
  } dpStrobe_t;
endpackage

// File: rtl/sra_ctrl.sv
module sra_ctrl #(
  parameter int CLASS_W = 6,
  parameter int OFFS_W = 12,
  parameter logic [CLASS_W-1:0] CLASS_NARROW = 6'h18,
  parameter logic [CLASS_W-1:0] CLASS_WIDE = 6'h14,
  parameter logic [OFFS_W-1:0] REDIR_OFFSET = 12'h200
) (
  input  logic clk,
  input  logic rst,
  input  logic reqValid,
  input  logic [1:0] reqLevel,
  input  logic reqWrite,
  input  logic reqWide,
  input  logic reqSelHyp,
  input  logic hostMode,
  input  logic [2:0] nvBits,
  input  logic el2Enabled,
  input  logic vmTrapRd,
  input  logic vmTrapWr,
  input  logic fgtPresent,
  input  logic el3Present,
  input  logic el3FgtEn,
  input  logic fgtTrapRd,
  input  logic fgtTrapWr,
  input  logic el3WideEn,
  input  logic wideUndefPrio,
  input  logic el3UndefSel,
  input  logic el2WideEn,
  input  logic extCtlOn,
  output sra_pkg::dpStrobe_t strobe,
  output logic rspValid,
  output logic rspDone,
  output logic rspRedirect,
  output logic rspUndef,
  output logic rspTrap,
  output logic [1:0] trapLevel,
  output logic [CLASS_W-1:0] trapClass,
  output logic [OFFS_W-1:0] redirOffset
);
  import sra_pkg::*;

  outcome_e outSel;
  logic [1:0] tgtLvl;
  logic useHyp;

  logic fgtLive, vmHit, fgtHit, topOff, lvl2WideOff, doneNow;

  assign fgtLive = el2Enabled & fgtPresent & (~el3Present | el3FgtEn);
  assign vmHit = el2Enabled & (reqWrite ? vmTrapWr : vmTrapRd);
  assign fgtHit = fgtLive & (reqWrite ? fgtTrapWr : fgtTrapRd);
  assign topOff = reqWide & el3Present & ~el3WideEn;
  assign lvl2WideOff = reqWide & el2Enabled & (~extCtlOn | ~el2WideEn);

  // Decision chain, first match wins
  always_comb begin
    outSel = OUT_UNDEF;
    tgtLvl = 2'd0;
    useHyp = reqSelHyp;
    if (reqLevel == 2'd0) begin
      outSel = OUT_UNDEF;
    end else if (reqSelHyp && reqLevel == 2'd1) begin
      if (nvBits[0]) begin
        outSel = OUT_TRAP;
        tgtLvl = 2'd2;
      end
    end else if (reqLevel == 2'd3) begin
      outSel = OUT_DONE;
    end else if (reqLevel == 2'd2) begin
      if (topOff) begin
        if (!(wideUndefPrio | el3UndefSel)) begin
          outSel = OUT_TRAP;
          tgtLvl = 2'd3;
        end
      end else begin
        outSel = OUT_DONE;
        useHyp = reqSelHyp | hostMode;
      end
    end else begin
      if (topOff && wideUndefPrio) begin
        outSel = OUT_UNDEF;
      end else if (vmHit || fgtHit || lvl2WideOff) begin
        outSel = OUT_TRAP;
        tgtLvl = 2'd2;
      end else if (topOff) begin
        if (!el3UndefSel) begin
          outSel = OUT_TRAP;
          tgtLvl = 2'd3;
        end
      end else if (&nvBits) begin
        outSel = OUT_REDIR;
      end else begin
        outSel = OUT_DONE;
      end
    end
  end

  assign doneNow = reqValid & (outSel == OUT_DONE);

  always_comb begin
    strobe.wrHypLo   = doneNow & reqWrite & useHyp;
    strobe.wrHypHi   = doneNow & reqWrite & useHyp & reqWide;
    strobe.wrGuestLo = doneNow & reqWrite & ~useHyp;
    strobe.wrGuestHi = doneNow & reqWrite & ~useHyp & reqWide;
    strobe.rdHyp     = doneNow & ~reqWrite & useHyp;
    strobe.rdGuest   = doneNow & ~reqWrite & ~useHyp;
    strobe.rdWide    = reqWide;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rspValid <= 1'b0;
      rspDone <= 1'b0;
      rspRedirect <= 1'b0;
      rspUndef <= 1'b0;
      rspTrap <= 1'b0;
      trapLevel <= '0;
      trapClass <= '0;
      redirOffset <= '0;
    end else begin
      rspValid <= reqValid;
      rspDone <= reqValid & (outSel == OUT_DONE);
      rspRedirect <= reqValid & (outSel == OUT_REDIR);
      rspUndef <= reqValid & (outSel == OUT_UNDEF);
      rspTrap <= reqValid & (outSel == OUT_TRAP);
      trapLevel <= (reqValid && outSel == OUT_TRAP) ? tgtLvl : 2'd0;
      trapClass <= (reqValid && outSel == OUT_TRAP) ? (reqWide ? CLASS_WIDE : CLASS_NARROW) : '0;
      redirOffset <= (reqValid && outSel == OUT_REDIR) ? REDIR_OFFSET : '0;
    end
  end
endmodule

// File: rtl/sra_datapath.sv
module sra_datapath #(
  parameter int HALF_W = 64,
  parameter int ASID_FULL = 16,
  parameter int ASID_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  sra_pkg::dpStrobe_t strobe,
  input  logic [HALF_W-1:0] wrLo,
  input  logic [HALF_W-1:0] wrHi,
  output logic [HALF_W-1:0] rdLo,
  output logic [HALF_W-1:0] rdHi
);
  localparam int ASID_PAD = ASID_FULL - ASID_W;
  localparam int REG_W = 2 * HALF_W;

  logic [REG_W-1:0] guestReg, hypReg;
  logic [HALF_W-1:0] loStore;

  // Narrow identifier variant clears the unused top identifier bits
  generate
    if (ASID_PAD > 0) begin : g_narrowId
      localparam logic [HALF_W-1:0] LO_KEEP = {HALF_W{1'b1}} >> ASID_PAD;
      assign loStore = wrLo & LO_KEEP;
    end else begin : g_fullId
      assign loStore = wrLo;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      guestReg <= '0;
      hypReg <= '0;
    end else begin
      if (strobe.wrGuestLo) guestReg[HALF_W-1:0] <= loStore;
      if (strobe.wrGuestHi) guestReg[REG_W-1:HALF_W] <= wrHi;
      if (strobe.wrHypLo) hypReg[HALF_W-1:0] <= loStore;
      if (strobe.wrHypHi) hypReg[REG_W-1:HALF_W] <= wrHi;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdLo <= '0;
      rdHi <= '0;
    end else if (strobe.rdHyp) begin
      rdLo <= hypReg[HALF_W-1:0];
      rdHi <= strobe.rdWide ? hypReg[REG_W-1:HALF_W] : '0;
    end else if (strobe.rdGuest) begin
      rdLo <= guestReg[HALF_W-1:0];
      rdHi <= strobe.rdWide ? guestReg[REG_W-1:HALF_W] : '0;
    end else begin
      rdLo <= '0;
      rdHi <= '0;
    end
  end
endmodule

// File: rtl/sysreg_access_ctrl.sv
module sysreg_access_ctrl #(
  parameter int HALF_W = 64,
  parameter int ASID_W = 8,
  parameter int CLASS_W = 6,
  parameter int OFFS_W = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic reqValid,
  input  logic [1:0] reqLevel,
  input  logic reqWrite,
  input  logic reqWide,
  input  logic reqSelHyp,
  input  logic [HALF_W-1:0] wrLo,
  input  logic [HALF_W-1:0] wrHi,
  input  logic hostMode,
  input  logic [2:0] nvBits,
  input  logic el2Enabled,
  input  logic vmTrapRd,
  input  logic vmTrapWr,
  input  logic fgtPresent,
  input  logic el3Present,
  input  logic el3FgtEn,
  input  logic fgtTrapRd,
  input  logic fgtTrapWr,
  input  logic el3WideEn,
  input  logic wideUndefPrio,
  input  logic el3UndefSel,
  input  logic el2WideEn,
  input  logic extCtlOn,
  output logic rspValid,
  output logic rspDone,
  output logic rspRedirect,
  output logic rspUndef,
  output logic rspTrap,
  output logic [1:0] trapLevel,
  output logic [CLASS_W-1:0] trapClass,
  output logic [OFFS_W-1:0] redirOffset,
  output logic [HALF_W-1:0] rdLo,
  output logic [HALF_W-1:0] rdHi
);
  sra_pkg::dpStrobe_t strobe;

  sra_ctrl #(.CLASS_W(CLASS_W), .OFFS_W(OFFS_W)) u_ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqLevel(reqLevel),
    .reqWrite(reqWrite), .reqWide(reqWide), .reqSelHyp(reqSelHyp),
    .hostMode(hostMode), .nvBits(nvBits), .el2Enabled(el2Enabled),
    .vmTrapRd(vmTrapRd), .vmTrapWr(vmTrapWr), .fgtPresent(fgtPresent),
    .el3Present(el3Present), .el3FgtEn(el3FgtEn), .fgtTrapRd(fgtTrapRd),
    .fgtTrapWr(fgtTrapWr), .el3WideEn(el3WideEn), .wideUndefPrio(wideUndefPrio),
    .el3UndefSel(el3UndefSel), .el2WideEn(el2WideEn), .extCtlOn(extCtlOn),
    .strobe(strobe), .rspValid(rspValid), .rspDone(rspDone),
    .rspRedirect(rspRedirect), .rspUndef(rspUndef), .rspTrap(rspTrap),
    .trapLevel(trapLevel), .trapClass(trapClass), .redirOffset(redirOffset)
  );

  sra_datapath #(.HALF_W(HALF_W), .ASID_W(ASID_W)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .wrLo(wrLo), .wrHi(wrHi),
    .rdLo(rdLo), .rdHi(rdHi)
  );
endmodule

// File: rtl/sra_access_checker.sv
module sra_access_checker (
  input logic clk,
  input logic rst,
  input logic reqValid,
  input logic [1:0] reqLevel,
  input logic reqWrite,
  input logic reqWide,
  input logic reqSelHyp,
  input logic [2:0] nvBits,
  input logic el2Enabled,
  input logic rspValid,
  input logic rspDone,
  input logic rspRedirect,
  input logic rspUndef,
  input logic rspTrap,
  input logic [1:0] trapLevel,
  input logic [5:0] trapClass,
  input logic [11:0] redirOffset,
  input logic [63:0] rdLo,
  input logic [63:0] rdHi
);
  assert_one_outcome_R10: assert property (@(posedge clk) disable iff (rst)
    rspValid |-> $countones({rspDone, rspRedirect, rspUndef, rspTrap}) == 1);

  assert_no_spurious_R10: assert property (@(posedge clk) disable iff (rst)
    !reqValid |=> !rspValid);

  assert_level0_undef_R1: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqLevel == 2'd0) |=> rspUndef);

  assert_hyp_l1_trap_R2: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqLevel == 2'd1 && reqSelHyp && nvBits[0]) |=>
      (rspTrap && trapLevel == 2'd2 &&
       trapClass == ($past(reqWide) ? 6'h14 : 6'h18)));

  assert_redirect_R6: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqLevel == 2'd1 && !reqSelHyp && !reqWide &&
     nvBits == 3'b111 && !el2Enabled) |=> (rspRedirect && redirOffset == 12'h200));

  assert_rd_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (rspValid && !rspDone) |-> (rdLo == 64'd0 && rdHi == 64'd0));

  assert_narrow_hi_R3: assert property (@(posedge clk) disable iff (rst)
    (reqValid && !reqWide) |=> rdHi == 64'd0);

  assert_level3_done_R10: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqLevel == 2'd3) |=> rspDone);
endmodule

bind sysreg_access_ctrl sra_access_checker u_sra_access_checker (.*);

// File: tb/sysreg_access_ctrl_bench.sv
module sysreg_access_ctrl_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reqValid = 1'b0;
  logic [1:0] reqLevel = '0;
  logic reqWrite = 1'b0, reqWide = 1'b0, reqSelHyp = 1'b0;
  logic [63:0] wrLo = '0, wrHi = '0;
  logic hostMode = 0, el2Enabled = 0, vmTrapRd = 0, vmTrapWr = 0;
  logic [2:0] nvBits = '0;
  logic fgtPresent = 0, el3Present = 0, el3FgtEn = 0, fgtTrapRd = 0, fgtTrapWr = 0;
  logic el3WideEn = 1, wideUndefPrio = 0, el3UndefSel = 0, el2WideEn = 1, extCtlOn = 1;
  logic rspValid, rspDone, rspRedirect, rspUndef, rspTrap;
  logic [1:0] trapLevel;
  logic [5:0] trapClass;
  logic [11:0] redirOffset;
  logic [63:0] rdLo, rdHi;

  sysreg_access_ctrl u_sysreg_access_ctrl (.*);

  always #5 clk = ~clk;

  typedef struct {
    logic [3:0] outc;     // {done, redirect, undef, trap}
    logic [1:0] lvl;
    logic [5:0] cls;
    logic [11:0] offs;
    logic [63:0] lo;
    logic [63:0] hi;
    string tag;
  } expItem_t;

  expItem_t expQ[$];
  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;
  logic [127:0] mGuest = '0, mHyp = '0;

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  // Driver: reference model from the requirements, pushes expectation
  task automatic issue(input logic [1:0] lv, input bit wr, input bit wide,
                       input bit hyp, input logic [63:0] lo, input logic [63:0] hi,
                       input string tag);
    expItem_t e;
    bit topOff, fgtOn, toHyp;
    e.outc = 4'b0000; e.lvl = 0; e.cls = 0; e.offs = 0; e.lo = 0; e.hi = 0; e.tag = tag;
    topOff = wide && el3Present && !el3WideEn;
    fgtOn = el2Enabled && fgtPresent && (!el3Present || el3FgtEn);
    toHyp = hyp;
    if (lv == 0) e.outc = 4'b0010;
    else if (hyp && lv == 1) begin
      if (nvBits[0]) begin e.outc = 4'b0001; e.lvl = 2; end else e.outc = 4'b0010;
    end else if (lv == 3) e.outc = 4'b1000;
    else if (lv == 2) begin
      if (topOff) begin
        if (wideUndefPrio || el3UndefSel) e.outc = 4'b0010;
        else begin e.outc = 4'b0001; e.lvl = 3; end
      end else begin e.outc = 4'b1000; toHyp = hyp || hostMode; end
    end else begin
      if (topOff && wideUndefPrio) e.outc = 4'b0010;
      else if (el2Enabled && (wr ? vmTrapWr : vmTrapRd)) begin e.outc = 4'b0001; e.lvl = 2; end
      else if (fgtOn && (wr ? fgtTrapWr : fgtTrapRd)) begin e.outc = 4'b0001; e.lvl = 2; end
      else if (wide && el2Enabled && (!extCtlOn || !el2WideEn)) begin e.outc = 4'b0001; e.lvl = 2; end
      else if (topOff) begin
        if (el3UndefSel) e.outc = 4'b0010; else begin e.outc = 4'b0001; e.lvl = 3; end
      end else if (nvBits == 3'b111) begin e.outc = 4'b0100; e.offs = 12'h200; end
      else e.outc = 4'b1000;
    end
    if (e.outc == 4'b0001) e.cls = wide ? 6'h14 : 6'h18;
    if (e.outc == 4'b1000) begin
      if (wr) begin
        if (toHyp) begin
          mHyp[63:0] = {8'h00, lo[55:0]};
          if (wide) mHyp[127:64] = hi;
        end else begin
          mGuest[63:0] = {8'h00, lo[55:0]};
          if (wide) mGuest[127:64] = hi;
        end
      end else begin
        e.lo = toHyp ? mHyp[63:0] : mGuest[63:0];
        e.hi = wide ? (toHyp ? mHyp[127:64] : mGuest[127:64]) : 64'd0;
      end
    end
    reqLevel = lv; reqWrite = wr; reqWide = wide; reqSelHyp = hyp;
    wrLo = lo; wrHi = hi; reqValid = 1'b1;
    expQ.push_back(e);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  // Monitor: compares each response with the head of the queue
  always @(negedge clk) begin
    if (!rst && rspValid) begin
      expItem_t e;
      vectors++;
      if (expQ.size() == 0) begin
        miscompares++;
        $display("FAIL R10: unexpected response, actual valid=1 expected none");
      end else begin
        e = expQ.pop_front();
        if ({rspDone, rspRedirect, rspUndef, rspTrap} != e.outc || trapLevel != e.lvl ||
            trapClass != e.cls || redirOffset != e.offs || rdLo != e.lo || rdHi != e.hi) begin
          miscompares++;
          $display("FAIL %s: actual outc=%b lvl=%0d cls=%h offs=%h lo=%h hi=%h expected outc=%b lvl=%0d cls=%h offs=%h lo=%h hi=%h",
                   e.tag, {rspDone, rspRedirect, rspUndef, rspTrap}, trapLevel, trapClass,
                   redirOffset, rdLo, rdHi, e.outc, e.lvl, e.cls, e.offs, e.lo, e.hi);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual run still active expected finished");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    vectors++;
    if (rspValid !== 1'b0) begin
      miscompares++;
      $display("FAIL R11: reset rspValid actual %b expected 0", rspValid);
    end
    issue(3, 0, 1, 0, 0, 0, "R11 guest reset value");
    issue(3, 0, 1, 1, 0, 0, "R11 hyp reset value");
    // R1
    issue(0, 0, 0, 1, 0, 0, "R1 level0 hyp read");
    issue(0, 1, 1, 0, 64'h1111, 64'h2222, "R1 level0 guest write");
    issue(3, 0, 1, 0, 0, 0, "R10 guest untouched after undef write");
    // R4 and R12
    issue(3, 1, 1, 1, 64'hFFAA_BBCC_DDEE_0011, 64'h0123_4567_89AB_CDEF, "R4 wide write hyp");
    issue(3, 0, 1, 1, 0, 0, "R4 R12 wide read hyp");
    // R3
    issue(2, 1, 0, 1, 64'hA5A5_0000_1234_5678, 64'hDEAD, "R3 narrow write hyp");
    issue(3, 0, 1, 1, 0, 0, "R3 upper half kept");
    issue(2, 0, 0, 1, 0, 0, "R3 narrow read upper zero");
    // R2
    nvBits = 3'b001;
    issue(1, 0, 0, 1, 0, 0, "R2 hyp L1 narrow trap");
    issue(1, 1, 1, 1, 64'h5, 64'h6, "R2 hyp L1 wide trap");
    nvBits = 3'b110;
    issue(1, 0, 0, 1, 0, 0, "R2 hyp L1 undef");
    issue(3, 0, 1, 1, 0, 0, "R10 hyp untouched after trap");
    nvBits = 3'b000;
    // R5
    hostMode = 1;
    issue(2, 1, 1, 0, 64'h0000_0000_0000_0D0D, 64'h0E0E, "R5 host write to hyp");
    issue(3, 0, 1, 1, 0, 0, "R5 hyp got host write");
    issue(3, 0, 1, 0, 0, 0, "R5 guest untouched");
    hostMode = 0;
    issue(2, 1, 1, 0, 64'h0000_7777_0000_0001, 64'h9999, "R5 non-host write to guest");
    issue(3, 0, 1, 0, 0, 0, "R5 guest got write");
    // R6
    el2Enabled = 1; vmTrapRd = 1;
    issue(1, 0, 0, 0, 0, 0, "R6 read trap");
    issue(1, 1, 0, 0, 64'h42, 0, "R6 read trap ignored on write");
    vmTrapRd = 0; vmTrapWr = 1;
    issue(1, 1, 0, 0, 64'h43, 0, "R6 write trap");
    issue(1, 0, 0, 0, 0, 0, "R6 read ok while write trap");
    vmTrapWr = 0;
    // R7
    fgtPresent = 1; fgtTrapRd = 1;
    issue(1, 0, 0, 0, 0, 0, "R7 fine-grained trap");
    el3Present = 1; el3FgtEn = 0;
    issue(1, 0, 0, 0, 0, 0, "R7 fine-grained gated by level3");
    el3FgtEn = 1; nvBits = 3'b111;
    issue(1, 0, 0, 0, 0, 0, "R6 fine-grained before redirect");
    fgtTrapRd = 0;
    issue(1, 1, 0, 0, 64'hBAD, 0, "R6 redirect");
    issue(3, 0, 1, 0, 0, 0, "R10 guest untouched after redirect");
    nvBits = 3'b000;
    // R8 and R9
    el3WideEn = 0; wideUndefPrio = 1;
    issue(2, 0, 1, 1, 0, 0, "R8 undef priority");
    wideUndefPrio = 0;
    issue(2, 0, 1, 1, 0, 0, "R8 trap to level3");
    issue(2, 0, 0, 1, 0, 0, "R8 narrow unaffected");
    el3UndefSel = 1;
    issue(2, 0, 1, 1, 0, 0, "R8 level3 undef");
    el3UndefSel = 0; el3WideEn = 1; el2WideEn = 0;
    issue(1, 0, 1, 0, 0, 0, "R9 level2 wide enable trap");
    el2WideEn = 1; extCtlOn = 0;
    issue(1, 0, 1, 0, 0, 0, "R9 extended control off trap");
    extCtlOn = 1; el3WideEn = 0;
    issue(1, 0, 1, 0, 0, 0, "R8 level1 trap to level3");
    wideUndefPrio = 1; vmTrapRd = 1;
    issue(1, 0, 1, 0, 0, 0, "R8 undef priority before read trap");
    wideUndefPrio = 0; vmTrapRd = 0; el3WideEn = 1;
    issue(1, 0, 1, 0, 0, 0, "R6 level1 guest wide read done");
    repeat (3) @(negedge clk);
    vectors++;
    if (expQ.size() != 0) begin
      miscompares++;
      $display("FAIL R10: missing responses actual %0d pending expected 0", expQ.size());
    end
    finishRun();
  end
endmodule